// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block measures the timing error between two pulse streams in a frequency synthesizer loop. One stream comes from the divided reference and the other from the divided VCO. Each stream arrives as a single-cycle strobe in the system clock domain. An edge-set flag latches each strobe. When both flags are set, they clear together on the next cycle. While exactly one flag is set, the block reports an error pulse whose width in cycles equals the distance between the two strobes.

There are three ways to read the error:

- A single-ended output, modelled as a drive enable plus a level. The enable low stands for the high-impedance (locked) state. The level is high when the VCO lags and low when the VCO leads.
- Two active-low outputs, one per path. These form a double-ended error signal that can be combined outside the block.
- A lock flag that is high whenever no error pulse is present.

Top module: `pfd_top`

## Requirements
- R1: After reset is released, and before any strobe arrives, errEn=0, refAheadN=1, vcoAheadN=1 and lockFlag=1.
- R2: When no error pulse is active and refStrobe arrives without vcoStrobe, the next cycle shows a high-going error: errEn=1, errLevel=1, refAheadN=0, vcoAheadN=1, lockFlag=0.
- R3: When no error pulse is active and vcoStrobe arrives without refStrobe, the next cycle shows a low-going error: errEn=1, errLevel=0, vcoAheadN=0, refAheadN=1, lockFlag=0.
- R4: While an error pulse is active, a strobe on the lagging input ends the pulse on the following cycle: errEn=0, both active-low outputs high, lockFlag=1.
- R5: Strobes on both inputs in the same cycle, with no pulse active, produce no error pulse.
- R6: If the lagging strobe arrives d cycles after the leading one, the error pulse lasts exactly d cycles.
- R7: Further strobes on the leading input during its own pulse have no effect on the outputs.
- R8: A strobe that arrives in the cycle where both flags are clearing is kept. A strobe on one input alone starts a new pulse on the next cycle, with the polarity given in R2 or R3.
- R9: lockFlag is high exactly when errEn is low. refAheadN and vcoAheadN are never low together. While errEn is high, errLevel is high exactly when refAheadN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refStrobe | input | 1 | Single-cycle pulse from the divided reference |
| vcoStrobe | input | 1 | Single-cycle pulse from the divided VCO |
| errEn | output | 1 | Single-ended error drive enable; 0 means high impedance |
| errLevel | output | 1 | Single-ended error level; 1 when VCO lags, 0 when VCO leads |
| refAheadN | output | 1 | Active low while the reference path is ahead |
| vcoAheadN | output | 1 | Active low while the VCO path is ahead |
| lockFlag | output | 1 | High while no error pulse is present |

## Verification
The assertions assume that each input is a clean strobe, sampled only at the rising clock edge. They also assume the strobes carry no meaning beyond their presence in a given cycle, so a strobe held high for several cycles counts as repeated strobes. The stimulus changes the inputs only on the falling edge and keeps every strobe to a single cycle. The stimulus for R7 deliberately repeats the leading strobe, which exercises that case rather than breaking the assumption.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Strobes from control to the flag datapath
  typedef struct packed {
    logic setRef;     // reference edge seen this cycle
    logic setVco;     // VCO edge seen this cycle
    logic clearBoth;  // both flags set: release them this cycle
  } pfdCtrl_t;

endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
(
  input  logic     refStrobe,
  input  logic     vcoStrobe,
  input  logic     refHeld,
  input  logic     vcoHeld,
  output pfdCtrl_t ctrl
);

  always_comb begin
    ctrl.setRef    = refStrobe;
    ctrl.setVco    = vcoStrobe;
    // coincidence reached: one full cycle of both flags, then release
    ctrl.clearBoth = refHeld & vcoHeld;
  end

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  pfdCtrl_t ctrl,
  output logic     refHeld,
  output logic     vcoHeld,
  output logic     errEn,
  output logic     errLevel,
  output logic     refAheadN,
  output logic     vcoAheadN,
  output logic     lockFlag
);

  logic refNext;
  logic vcoNext;

  always_comb begin
    if (ctrl.clearBoth) begin
      // a strobe landing on the release cycle is kept, not lost
      refNext = ctrl.setRef;
      vcoNext = ctrl.setVco;
    end else begin
      refNext = refHeld | ctrl.setRef;
      vcoNext = vcoHeld | ctrl.setVco;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refHeld <= 1'b0;
      vcoHeld <= 1'b0;
    end else begin
      refHeld <= refNext;
      vcoHeld <= vcoNext;
    end
  end

  logic refOnly;
  logic vcoOnly;

  always_comb begin
    refOnly   = refHeld & ~vcoHeld;
    vcoOnly   = vcoHeld & ~refHeld;
    errEn     = refOnly | vcoOnly;
    errLevel  = refOnly;
    refAheadN = ~refOnly;
    vcoAheadN = ~vcoOnly;
    lockFlag  = ~(refOnly | vcoOnly);
  end

endmodule

// File: rtl/pfd_top.sv
module pfd_top
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic refStrobe,
  input  logic vcoStrobe,
  output logic errEn,
  output logic errLevel,
  output logic refAheadN,
  output logic vcoAheadN,
  output logic lockFlag
);

  pfdCtrl_t ctrl;
  logic     refHeld;
  logic     vcoHeld;

  pfd_ctrl u_ctrl (
    .refStrobe (refStrobe),
    .vcoStrobe (vcoStrobe),
    .refHeld   (refHeld),
    .vcoHeld   (vcoHeld),
    .ctrl      (ctrl)
  );

  pfd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .refHeld   (refHeld),
    .vcoHeld   (vcoHeld),
    .errEn     (errEn),
    .errLevel  (errLevel),
    .refAheadN (refAheadN),
    .vcoAheadN (vcoAheadN),
    .lockFlag  (lockFlag)
  );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic clk,
  input logic rstN,
  input logic refStrobe,
  input logic vcoStrobe,
  input logic errEn,
  input logic errLevel,
  input logic refAheadN,
  input logic vcoAheadN,
  input logic lockFlag
);

  AST_REF_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && refStrobe && !vcoStrobe |=> errEn && errLevel && !refAheadN && !lockFlag); // R2

  AST_VCO_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && vcoStrobe && !refStrobe |=> errEn && !errLevel && !vcoAheadN && !lockFlag); // R3

  AST_LAG_ENDS_REF: assert property (@(posedge clk) disable iff (!rstN)
    !refAheadN && vcoStrobe |=> lockFlag && !errEn); // R4

  AST_LAG_ENDS_VCO: assert property (@(posedge clk) disable iff (!rstN)
    !vcoAheadN && refStrobe |=> lockFlag && !errEn); // R4

  AST_SIMULT_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && refStrobe && vcoStrobe |=> lockFlag); // R5

  AST_REF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !refAheadN && !vcoStrobe |=> !refAheadN); // R7

  AST_VCO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !vcoAheadN && !refStrobe |=> !vcoAheadN); // R7

  AST_SIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    refAheadN || vcoAheadN); // R9

  AST_LOCK_MATCHES_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag == !errEn); // R9

  AST_LEVEL_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    errEn |-> (errLevel == !refAheadN)); // R9

endmodule

bind pfd_top pfd_checker u_chk (.*);

// File: tb/sim_pfd_top.sv
module sim_pfd_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refStrobe = 1'b0;
  logic vcoStrobe = 1'b0;
  logic errEn, errLevel, refAheadN, vcoAheadN, lockFlag;

  always #5 clk = ~clk;

  pfd_top u0 (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .vcoStrobe(vcoStrobe),
    .errEn(errEn), .errLevel(errLevel), .refAheadN(refAheadN),
    .vcoAheadN(vcoAheadN), .lockFlag(lockFlag)
  );

  typedef struct {
    logic  en, lvl, refN, vcoN, lock;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // kind: 0 no pulse, 1 reference ahead, 2 VCO ahead
  function automatic expItem_t mkExp(int kind, string tag);
    expItem_t e;
    e.tag = tag;
    case (kind)
      1: begin e.en = 1; e.lvl = 1; e.refN = 0; e.vcoN = 1; e.lock = 0; end
      2: begin e.en = 1; e.lvl = 0; e.refN = 1; e.vcoN = 0; e.lock = 0; end
      default: begin e.en = 0; e.lvl = 0; e.refN = 1; e.vcoN = 1; e.lock = 1; end
    endcase
    return e;
  endfunction

  task automatic compare(expItem_t e);
    checks++;
    if (errEn !== e.en || (e.en && errLevel !== e.lvl) || refAheadN !== e.refN ||
        vcoAheadN !== e.vcoN || lockFlag !== e.lock) begin
      errors++;
      $display("FAIL %s: got en=%b lvl=%b refN=%b vcoN=%b lock=%b, expected en=%b lvl=%b refN=%b vcoN=%b lock=%b",
               e.tag, errEn, errLevel, refAheadN, vcoAheadN, lockFlag,
               e.en, e.lvl, e.refN, e.vcoN, e.lock);
    end
  endtask

  // driver: inputs on the falling edge, expectation for the state after the next rising edge
  task automatic step(logic r, logic v, int kind, string tag);
    @(negedge clk);
    refStrobe = r;
    vcoStrobe = v;
    expQ.push_back(mkExp(kind, tag));
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(mkExp(0, "R1 reset state"));

    // R2 R6 R4: reference leads by 3 cycles
    step(1, 0, 1, "R2 ref leads");
    step(0, 0, 1, "R6 width 3 cycle 2");
    step(0, 0, 1, "R6 width 3 cycle 3");
    step(0, 1, 0, "R4 vco closes pulse");
    step(0, 0, 0, "R4 stays locked");
    step(0, 0, 0, "R9 idle");

    // R3 R6: VCO leads by 2 cycles
    step(0, 1, 2, "R3 vco leads");
    step(0, 0, 2, "R6 width 2 cycle 2");
    step(1, 0, 0, "R4 ref closes pulse");
    step(0, 0, 0, "R4 stays locked");

    // R5: coincident strobes
    step(1, 1, 0, "R5 coincident");
    step(0, 0, 0, "R5 no later pulse");

    // R6: width 1
    step(0, 1, 2, "R6 width 1");
    step(1, 0, 0, "R6 width 1 ends");
    step(0, 0, 0, "R6 idle");

    // R7: repeated leading strobes ignored
    step(1, 0, 1, "R7 first ref");
    step(1, 0, 1, "R7 repeat ref");
    step(1, 0, 1, "R7 repeat ref again");
    step(0, 1, 0, "R7 single vco closes");
    step(0, 0, 0, "R7 idle");
    step(0, 1, 2, "R7 first vco");
    step(0, 1, 2, "R7 repeat vco");
    step(1, 0, 0, "R7 single ref closes");
    step(0, 0, 0, "R7 idle 2");

    // R8: strobe on the release cycle is kept
    step(1, 1, 0, "R8 coincident setup");
    step(1, 0, 1, "R8 ref kept on release");
    step(0, 1, 0, "R8 ref pulse closes");
    step(0, 0, 0, "R8 idle");
    step(0, 1, 2, "R8 vco leads");
    step(1, 0, 0, "R8 closes into release");
    step(0, 1, 2, "R8 vco kept on release");
    step(1, 0, 0, "R8 closes again");
    step(0, 0, 0, "R8 idle 2");

    @(negedge clk);
    refStrobe = 0;
    vcoStrobe = 0;
    repeat (3) @(negedge clk);
    done = 1;
    report();
  end

endmodule